// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block drives the column side of a synchronous DRAM core. Software programs it through a mode-set command that carries four things: the burst length, the wrap order, the read latency and whether writes burst or move a single word. When a read or write command arrives, the block captures the starting column. From the following cycle it produces one internal column address per clock, in the programmed order, until the burst completes. All inputs are taken on the rising clock edge.

Each column step of a read raises a data-valid strobe a fixed number of cycles later, and that number depends on the programmed latency. Each column step of a write raises a write-enable strobe in the same cycle as the step. A burst-stop command or a precharge command ends a burst early. A fresh read or write command cuts short whatever burst is running and starts a new one on any cycle.

Top module: `sdram_col_burst`

## Requirements
- R1: After reset, colValid, writeEn and readValid are low. The mode is burst length 1, sequential order, latency 3 and bursting writes.
- R2: When cmdModeSet is high, the block captures the mode word. The fields are: modeWord[2:0] length (000=1, 001=2, 010=4, 011=8, 111=full page), modeWord[3] order (0 sequential, 1 interleaved), modeWord[6:4] latency (010=2, 011=3) and modeWord[9] single-word writes. The block ignores the whole write if the length code or the latency code is reserved.
- R3: A read or write sampled at edge e0 makes colValid high from the next cycle for exactly the burst length of cycles, and the first colAddr equals the sampled colIn. writeEn follows colValid for writes and stays low for reads.
- R4: In sequential order, beat i (from 0) carries the low log2(length) bits (start+i) mod length. The upper column bits keep the start value.
- R5: In interleaved order, beat i carries the low bits start XOR i, and the upper bits keep the start value.
- R6: A full-page burst steps through all 256 columns in sequential order, ignoring the order bit. It wraps from 0xFF to 0x00 and runs until a terminating or new command arrives.
- R7: readValid is high in the cycle that lies latency-1 cycles after each read column cycle.
- R8: cmdStop or cmdPrecharge ends the burst. colValid and writeEn drop in the next cycle. For reads, readValid stays high for latency-1 further cycles and then drops.
- R9: With single-word writes enabled, a write issues one column while a read still uses the programmed length.
- R10: A read or write arriving during a burst restarts the sequence at the new column in the next cycle. Back-to-back reads keep readValid high without a gap.
- R11: A read or write sampled together with cmdStop or cmdPrecharge wins, and the new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdRead | input | 1 | Decoded read command |
| cmdWrite | input | 1 | Decoded write command |
| cmdStop | input | 1 | Decoded burst-stop command |
| cmdPrecharge | input | 1 | Decoded precharge command |
| cmdModeSet | input | 1 | Decoded mode register write |
| modeWord | input | MODE_W | Mode word on the address lines |
| colIn | input | COL_W | Start column of a read or write |
| colAddr | output | COL_W | Internal column address |
| colValid | output | 1 | colAddr is a live burst beat |
| writeEn | output | 1 | Write strobe for the current column |
| readValid | output | 1 | Read data valid, delayed by the latency |

## Verification
The bench uses start columns whose low bits sit partway through the wrap window, such as 0x2D with length 8 and 0x16 with length 4. With these starts, sequential and interleaved order produce different addresses, and a wrong upper-bit mask shows up. Runs at latency 2 and at latency 3 separate the two taps of the data-valid delay. A full-page run starting at 0xFD with the order bit set checks both the 256-column wrap and that the order bit is ignored for full pages. Stop and precharge are each placed mid-burst, on reads and on writes, to show the difference between the delayed read tail and the immediate write cutoff. Reserved mode codes, a read that interrupts a running read, and a read together with a stop in the same cycle cover the ordering corners.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;

  localparam logic [2:0] LAT_TWO   = 3'b010;
  localparam logic [2:0] LAT_THREE = 3'b011;

  // field positions inside the mode word
  localparam int LEN_LSB   = 0;
  localparam int ORDER_BIT = 3;
  localparam int LAT_LSB   = 4;
  localparam int WSGL_BIT  = 9;

  typedef struct packed {
    logic [2:0] lenCode;
    logic       interleave;
    logic       lat3;
    logic       singleWrite;
  } modeT;

  typedef struct packed {
    logic load;       // capture start column, clear beat
    logic step;       // advance beat
    logic singleLen;  // current burst is a one-word write
  } burstStrobeT;

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_burst_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdModeSet,
  input  logic [MODE_W-1:0] modeWord,
  output modeT              mode
);

  logic [2:0] lenField;
  logic [2:0] latField;
  logic       lenOk;
  logic       latOk;

  assign lenField = modeWord[LEN_LSB +: 3];
  assign latField = modeWord[LAT_LSB +: 3];

  always_comb begin
    unique case (lenField)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT, LEN_PAGE: lenOk = 1'b1;
      default:                                         lenOk = 1'b0;
    endcase
    latOk = (latField == LAT_TWO) || (latField == LAT_THREE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode.lenCode     <= LEN_ONE;
      mode.interleave  <= 1'b0;
      mode.lat3        <= 1'b1;
      mode.singleWrite <= 1'b0;
    end else if (cmdModeSet && lenOk && latOk) begin
      mode.lenCode     <= lenField;
      mode.interleave  <= modeWord[ORDER_BIT];
      mode.lat3        <= (latField == LAT_THREE);
      mode.singleWrite <= modeWord[WSGL_BIT];
    end
  end

endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdRead,
  input  logic        cmdWrite,
  input  logic        cmdStop,
  input  logic        cmdPrecharge,
  input  modeT        mode,
  input  logic        lastBeat,
  output burstStrobeT strobe,
  output logic        active,
  output logic        isWrite
);

  logic rwCmd;
  logic termCmd;

  assign rwCmd   = cmdRead | cmdWrite;
  assign termCmd = cmdStop | cmdPrecharge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      isWrite <= 1'b0;
    end else if (rwCmd) begin
      active  <= 1'b1;
      isWrite <= !cmdRead;
    end else if (termCmd) begin
      active  <= 1'b0;
    end else if (active && lastBeat) begin
      active  <= 1'b0;
    end
  end

  always_comb begin
    strobe.load      = rwCmd;
    strobe.step      = active && !lastBeat && !rwCmd && !termCmd;
    strobe.singleLen = isWrite && mode.singleWrite;
  end

endmodule

// File: rtl/sdram_col_datapath.sv
module sdram_col_datapath
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStrobeT      strobe,
  input  modeT             mode,
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat
);

  logic [COL_W-1:0] startCol;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] lenMask;
  logic [COL_W-1:0] effMask;
  logic [COL_W-1:0] lowBits;
  logic             fullPage;
  logic             useIlv;

  always_comb begin
    unique case (mode.lenCode)
      LEN_ONE:   lenMask = '0;
      LEN_TWO:   lenMask = COL_W'(1);
      LEN_FOUR:  lenMask = COL_W'(3);
      LEN_EIGHT: lenMask = COL_W'(7);
      default:   lenMask = '1;
    endcase
    fullPage = (mode.lenCode == LEN_PAGE) && !strobe.singleLen;
    effMask  = strobe.singleLen ? '0 : lenMask;
    useIlv   = mode.interleave && !fullPage;
    lowBits  = useIlv ? (startCol ^ beat) : (startCol + beat);
    colAddr  = (startCol & ~effMask) | (lowBits & effMask);
    lastBeat = !fullPage && (beat == effMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCol <= '0;
      beat     <= '0;
    end else if (strobe.load) begin
      startCol <= colIn;
      beat     <= '0;
    end else if (strobe.step) begin
      beat     <= beat + COL_W'(1);
    end
  end

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rdIssue,
  input  logic lat3,
  output logic readValid
);

  localparam int DEPTH = MAX_LAT - 1;

  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= 1'b0;
    else       stage[0] <= rdIssue;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_delay
    always_ff @(posedge clk) begin
      if (!rstN) stage[k] <= 1'b0;
      else       stage[k] <= stage[k-1];
    end
  end

  assign readValid = lat3 ? stage[MAX_LAT-2] : stage[MIN_LAT-2];

endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdRead,
  input  logic              cmdWrite,
  input  logic              cmdStop,
  input  logic              cmdPrecharge,
  input  logic              cmdModeSet,
  input  logic [MODE_W-1:0] modeWord,
  input  logic [COL_W-1:0]  colIn,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              writeEn,
  output logic              readValid
);

  modeT        mode;
  burstStrobeT strobe;
  logic        lastBeat;
  logic        active;
  logic        isWrite;

  sdram_mode_reg #(.MODE_W(MODE_W)) modeRegI (
    .clk(clk), .rstN(rstN), .cmdModeSet(cmdModeSet),
    .modeWord(modeWord), .mode(mode)
  );

  sdram_burst_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .cmdStop(cmdStop), .cmdPrecharge(cmdPrecharge), .mode(mode),
    .lastBeat(lastBeat), .strobe(strobe), .active(active), .isWrite(isWrite)
  );

  sdram_col_datapath #(.COL_W(COL_W)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .colIn(colIn), .colAddr(colAddr), .lastBeat(lastBeat)
  );

  sdram_read_pipe rdPipeI (
    .clk(clk), .rstN(rstN), .rdIssue(active && !isWrite),
    .lat3(mode.lat3), .readValid(readValid)
  );

  assign colValid = active;
  assign writeEn  = active && isWrite;

endmodule

// File: rtl/sdram_col_burst_chk.sv
module sdram_col_burst_chk #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdRead,
  input logic              cmdWrite,
  input logic              cmdStop,
  input logic              cmdPrecharge,
  input logic [COL_W-1:0]  colIn,
  input logic [COL_W-1:0]  colAddr,
  input logic              colValid,
  input logic              writeEn,
  input logic              readValid
);

  assert_first_col_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead || cmdWrite) |=> (colValid && colAddr == $past(colIn)));

  assert_write_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !cmdRead) |=> writeEn);

  assert_read_no_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdRead |=> !writeEn);

  assert_term_cut_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdStop || cmdPrecharge) && !cmdRead && !cmdWrite) |=> (!colValid && !writeEn));

  assert_rd_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> ($past(colValid && !writeEn) || $past(colValid && !writeEn, 2)));

endmodule

bind sdram_col_burst sdram_col_burst_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) chkI (
  .clk(clk), .rstN(rstN), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
  .cmdStop(cmdStop), .cmdPrecharge(cmdPrecharge), .colIn(colIn),
  .colAddr(colAddr), .colValid(colValid), .writeEn(writeEn), .readValid(readValid)
);

// File: tb/sdram_col_burst_test.sv
`timescale 1ns/1ps
module sdram_col_burst_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdRead, cmdWrite, cmdStop, cmdPrecharge, cmdModeSet;
  logic [11:0] modeWord;
  logic [7:0]  colIn;
  logic [7:0]  colAddr;
  logic        colValid, writeEn, readValid;

  int vectors = 0;
  int errors  = 0;

  // bench-side mode model; mLen 0 means full page
  int mLen = 1;
  bit mIlv = 0;
  int mLat = 3;
  bit mSgl = 0;

  always #2.5 clk = ~clk;

  sdram_col_burst uut (
    .clk(clk), .rstN(rstN), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .cmdStop(cmdStop), .cmdPrecharge(cmdPrecharge), .cmdModeSet(cmdModeSet),
    .modeWord(modeWord), .colIn(colIn), .colAddr(colAddr),
    .colValid(colValid), .writeEn(writeEn), .readValid(readValid)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic setMode(logic [2:0] lenC, bit ilv, logic [2:0] latC, bit sgl);
    @(negedge clk);
    modeWord      = '0;
    modeWord[2:0] = lenC;
    modeWord[3]   = ilv;
    modeWord[6:4] = latC;
    modeWord[9]   = sgl;
    cmdModeSet    = 1'b1;
    @(negedge clk);
    cmdModeSet = 1'b0;
    if ((lenC inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111}) &&
        (latC inside {3'b010, 3'b011})) begin
      mLen = (lenC == 3'b111) ? 0 : (1 << lenC);
      mIlv = ilv;
      mLat = (latC == 3'b011) ? 3 : 2;
      mSgl = sgl;
    end
  endtask

  // expected column of beat j (1-based)
  function automatic logic [7:0] expCol(logic [7:0] start, int j, bit full, int len);
    logic [7:0] mask;
    logic [7:0] low;
    mask = full ? 8'hFF : 8'(len - 1);
    low  = (mIlv && !full) ? (start ^ 8'(j - 1)) : (start + 8'(j - 1));
    return (start & ~mask) | (low & mask);
  endfunction

  // termKind: 0 none, 1 stop, 2 precharge; termAt = sample index where it is driven
  task automatic runBurst(bit isW, logic [7:0] start, int termAt, int termKind,
                          int nSamples, string tag);
    bit full;
    int len;
    full = (mLen == 0) && !(isW && mSgl);
    len  = (isW && mSgl) ? 1 : mLen;
    @(negedge clk);
    colIn    = start;
    cmdRead  = !isW;
    cmdWrite = isW;
    for (int i = 1; i <= nSamples; i++) begin
      bit iss;
      bit rdExp;
      int r;
      @(negedge clk);
      cmdRead      = 1'b0;
      cmdWrite     = 1'b0;
      cmdStop      = 1'b0;
      cmdPrecharge = 1'b0;
      iss = (full || i <= len) && (termAt == 0 || i <= termAt);
      r   = i - mLat + 1;
      rdExp = !isW && r >= 1 && (full || r <= len) && (termAt == 0 || r <= termAt);
      check(tag, "colValid", 32'(colValid), 32'(iss));
      check(tag, "writeEn", 32'(writeEn), 32'(iss && isW));
      check(tag, "readValid", 32'(readValid), 32'(rdExp));
      if (iss) check(tag, "colAddr", 32'(colAddr), 32'(expCol(start, i, full, len)));
      if (i == termAt) begin
        if (termKind == 1) cmdStop = 1'b1;
        else               cmdPrecharge = 1'b1;
      end
    end
  endtask

  task automatic testReset();
    check("R1", "colValid", 32'(colValid), 32'd0);
    check("R1", "writeEn", 32'(writeEn), 32'd0);
    check("R1", "readValid", 32'(readValid), 32'd0);
    // default mode: length 1, latency 3
    runBurst(1'b0, 8'h37, 0, 0, 5, "R1");
  endtask

  task automatic testSequential();
    setMode(3'b011, 1'b0, 3'b010, 1'b0);
    runBurst(1'b0, 8'h2D, 0, 0, 11, "R4");
    setMode(3'b001, 1'b0, 3'b011, 1'b0);
    runBurst(1'b1, 8'h93, 0, 0, 6, "R3");
  endtask

  task automatic testInterleave();
    setMode(3'b010, 1'b1, 3'b011, 1'b0);
    runBurst(1'b1, 8'h16, 0, 0, 7, "R5");
    setMode(3'b011, 1'b1, 3'b011, 1'b0);
    runBurst(1'b0, 8'h0B, 0, 0, 12, "R5");
  endtask

  task automatic testReserved();
    // both writes below carry a reserved code and must leave length 8, interleaved, latency 3
    setMode(3'b100, 1'b0, 3'b010, 1'b0);
    setMode(3'b001, 1'b0, 3'b001, 1'b0);
    runBurst(1'b0, 8'h5A, 0, 0, 12, "R2");
  endtask

  task automatic testFullPage();
    setMode(3'b111, 1'b1, 3'b010, 1'b0);
    runBurst(1'b0, 8'hFD, 260, 1, 263, "R6");
    setMode(3'b111, 1'b0, 3'b011, 1'b0);
    runBurst(1'b1, 8'h10, 5, 1, 9, "R8");
  endtask

  task automatic testPrecharge();
    setMode(3'b011, 1'b0, 3'b011, 1'b0);
    runBurst(1'b0, 8'h80, 3, 2, 8, "R8");
    runBurst(1'b1, 8'hC4, 2, 2, 6, "R8");
  endtask

  task automatic testSingleWrite();
    setMode(3'b010, 1'b0, 3'b010, 1'b1);
    runBurst(1'b1, 8'h21, 0, 0, 5, "R9");
    runBurst(1'b0, 8'h21, 0, 0, 7, "R9");
  endtask

  task automatic testInterrupt();
    setMode(3'b011, 1'b0, 3'b010, 1'b0);
    @(negedge clk);
    colIn   = 8'h10;
    cmdRead = 1'b1;
    for (int i = 1; i <= 13; i++) begin
      bit iss;
      logic [7:0] ea;
      @(negedge clk);
      cmdRead = 1'b0;
      iss = (i <= 11);
      ea  = (i <= 3) ? 8'(8'h10 + i - 1) : 8'(8'h40 + i - 4);
      check("R10", "colValid", 32'(colValid), 32'(iss));
      if (iss) check("R10", "colAddr", 32'(colAddr), 32'(ea));
      check("R10", "readValid", 32'(readValid), 32'(i >= 2 && i <= 12));
      if (i == 3) begin
        colIn   = 8'h40;
        cmdRead = 1'b1;
      end
    end
  endtask

  task automatic testPriority();
    setMode(3'b010, 1'b0, 3'b010, 1'b0);
    @(negedge clk);
    colIn   = 8'h66;
    cmdRead = 1'b1;
    cmdStop = 1'b1;
    @(negedge clk);
    cmdRead = 1'b0;
    cmdStop = 1'b0;
    check("R11", "colValid", 32'(colValid), 32'd1);
    check("R11", "colAddr", 32'(colAddr), 32'h66);
    @(negedge clk);
    check("R11", "colAddr", 32'(colAddr), 32'h67);
    check("R11", "readValid", 32'(readValid), 32'd1);
    repeat (4) @(negedge clk);
    check("R11", "colValid", 32'(colValid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    cmdRead = 1'b0; cmdWrite = 1'b0; cmdStop = 1'b0;
    cmdPrecharge = 1'b0; cmdModeSet = 1'b0;
    modeWord = '0; colIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSequential();
    testInterleave();
    testReserved();
    testFullPage();
    testPrecharge();
    testSingleWrite();
    testInterrupt();
    testPriority();
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule